// File: doc/BRIEF.md
# Clear-on-Read Interrupt Status Aggregator

This block collects single-cycle event pulses from the transmit, receive, bus-error, power-management, PHY, software and statistics engines of a network controller. It holds each one in a sticky bit of a 32-bit status word. A companion mask word decides which pending bits may raise the interrupt line. Software reads the status word to learn which sources fired. That same read empties the whole word, so each event is reported once.

Two sources arrive as levels rather than pulses, and the block turns each into an event itself. The transmit state machine's idle level records an event only when it goes from busy to idle. A mirrored configuration parity flag records an event when it rises. Bit 15 is not stored. It is a summary that reads as 1 whenever any bit from 16 to 25 is set. After reset, both reset-complete flags and the summary read as 1.

Top module: `irq_status_agg`

## Requirements
- R1: After reset the status word reads 0x03008000, the mask word reads 0 and irqOut is 0.
- R2: A pulse on an event input sets its status bit, which reads as 1 from the next cycle on. The bit positions are: txPktErr 8, txUnderrun 10, statService 11, swiCmd 12, pmEvent 13, phyIrq 14, rxStatOvr 16, targetAbort 20, masterAbort 21, sysErr 22, rxResetDone 24, txResetDone 25. A set bit stays set until a status read.
- R3: A read with regSel=0 and rdEn=1 returns the current status word on rdData in the same cycle. From the next cycle every status bit is 0, except bits whose event arrived in the read cycle, which read as 1.
- R4: A write with regSel=0 leaves the status word unchanged.
- R5: Status bit 15 reads as the OR of status bits 25 down to 16.
- R6: Status bit 9 is set only in the cycle after txIdle goes from 0 to 1. Holding txIdle at 1, or a fall of txIdle, sets nothing. The idle history resets to 1.
- R7: Status bit 23 is set in the cycle after parityFlag goes from 0 to 1. Holding the flag high does not set the bit again after a clearing read.
- R8: A write with regSel=1 loads the mask word, and a read with regSel=1 returns it. Bits outside 25..20, 16..8 are forced to 0. Reading the mask does not clear the status word.
- R9: irqOut is registered. In each cycle it equals the OR over all bits of (status AND mask) as that status and mask read in the same cycle. Status bits set regardless of the mask. After a clearing read with no new event, irqOut is 0 in the next cycle.
- R10: Status bits 31..26 and 19..17 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rdEn | input | 1 | Register read strobe |
| wrEn | input | 1 | Register write strobe |
| regSel | input | 1 | Register select: 0 = status, 1 = mask |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data (0 when rdEn is low) |
| txResetDone | input | 1 | Transmit reset complete pulse |
| rxResetDone | input | 1 | Receive reset complete pulse |
| sysErr | input | 1 | System error signaled pulse |
| masterAbort | input | 1 | Master abort received pulse |
| targetAbort | input | 1 | Target abort received pulse |
| rxStatOvr | input | 1 | Receive status FIFO overrun pulse |
| phyIrq | input | 1 | PHY interrupt pulse |
| pmEvent | input | 1 | Power management wake event pulse |
| swiCmd | input | 1 | Software interrupt command pulse |
| statService | input | 1 | Statistics threshold pulse |
| txUnderrun | input | 1 | Transmit FIFO underrun pulse |
| txIdle | input | 1 | Transmit state machine idle level |
| txPktErr | input | 1 | Transmit packet error pulse |
| parityFlag | input | 1 | Mirrored configuration parity flag level |
| irqOut | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its default 32-bit word, which fixes the implemented-bit pattern and the reset value that every check relies on. With that word, every event position, the summary range and the reserved gaps can be reached directly. Random mixes of pulses, reads, writes and level changes on txIdle and parityFlag often land an event in the same cycle as a clearing read, and the bench checks that those bits survive. Directed steps cover the reset value, ignored status writes, mask writes to reserved bits, held levels on the two edge-detected inputs, and irqOut falling right after a clearing read.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int REG_W  = 32;
  localparam int SUM_LO = 16;
  localparam int SUM_HI = 25;
  localparam int SUM_BIT = 15;
  localparam int TXIDLE_BIT = 9;
  localparam int PARITY_BIT = 23;
  // bits that can be set by an event (summary bit excluded: it is derived)
  localparam logic [REG_W-1:0] STORE_MASK = 32'h03F1_7F00;
  // bits that exist in the register view and in the mask
  localparam logic [REG_W-1:0] IMPL_MASK  = STORE_MASK | (32'd1 << SUM_BIT);
  // stored reset value: both reset-complete flags preset
  localparam logic [REG_W-1:0] STAT_RST   = 32'h0300_0000;

  typedef struct packed {
    logic clrStatus;
    logic ldMask;
    logic txIdleEvt;
    logic parityEvt;
  } strobe_t;
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    rdEn,
  input  logic    wrEn,
  input  logic    regSel,
  input  logic    txIdle,
  input  logic    parityFlag,
  output strobe_t strb
);
  logic prevTxIdle;
  logic prevParity;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevTxIdle <= 1'b1;
      prevParity <= 1'b0;
    end else begin
      prevTxIdle <= txIdle;
      prevParity <= parityFlag;
    end
  end

  always_comb begin
    strb.clrStatus = rdEn && !regSel;
    strb.ldMask    = wrEn && regSel;
    strb.txIdleEvt = txIdle && !prevTxIdle;
    strb.parityEvt = parityFlag && !prevParity;
  end

  // R6
  tx_idle_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.txIdleEvt |-> (txIdle && !$past(txIdle)));
  // R7
  parity_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (parityFlag && $past(parityFlag)) |-> !strb.parityEvt);
endmodule

// File: rtl/irq_agg_dp.sv
module irq_agg_dp
  import irq_agg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [REG_W-1:0] evtIn,
  input  logic [REG_W-1:0] wrData,
  input  logic             rdEn,
  input  logic             regSel,
  output logic [REG_W-1:0] rdData,
  output logic             irqOut
);
  logic [REG_W-1:0] statusReg, statusNext, statusView, viewNext;
  logic [REG_W-1:0] maskReg, maskNext, evtAll;

  function automatic logic [REG_W-1:0] viewOf(input logic [REG_W-1:0] s);
    logic [REG_W-1:0] v;
    v = s & STORE_MASK;
    v[SUM_BIT] = |s[SUM_HI:SUM_LO];
    return v;
  endfunction

  always_comb begin
    evtAll = evtIn;
    evtAll[TXIDLE_BIT] = evtIn[TXIDLE_BIT] | strb.txIdleEvt;
    evtAll[PARITY_BIT] = evtIn[PARITY_BIT] | strb.parityEvt;
    evtAll = evtAll & STORE_MASK;
    statusNext = ((strb.clrStatus ? '0 : statusReg) | evtAll) & STORE_MASK;
    maskNext   = strb.ldMask ? (wrData & IMPL_MASK) : maskReg;
    statusView = viewOf(statusReg);
    viewNext   = viewOf(statusNext);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusReg <= STAT_RST;
      maskReg   <= '0;
      irqOut    <= 1'b0;
    end else begin
      statusReg <= statusNext;
      maskReg   <= maskNext;
      irqOut    <= |(viewNext & maskNext);
    end
  end

  always_comb begin
    if (!rdEn)       rdData = '0;
    else if (regSel) rdData = maskReg;
    else             rdData = statusView;
  end

  // R2
  event_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|evtAll) |=> ((statusReg & $past(evtAll)) == $past(evtAll)));
  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrStatus |=> ((statusReg & $past(statusReg)) == $past(statusReg)));
  // R3
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrStatus |=> ((statusReg & ~$past(evtAll)) == '0));
  // R9
  irq_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == |(statusView & maskReg));
  // R8
  mask_reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskReg & ~IMPL_MASK) == '0);
  // R10
  status_reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusReg & ~STORE_MASK) == '0);
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdEn,
  input  logic             wrEn,
  input  logic             regSel,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             txResetDone,
  input  logic             rxResetDone,
  input  logic             sysErr,
  input  logic             masterAbort,
  input  logic             targetAbort,
  input  logic             rxStatOvr,
  input  logic             phyIrq,
  input  logic             pmEvent,
  input  logic             swiCmd,
  input  logic             statService,
  input  logic             txUnderrun,
  input  logic             txIdle,
  input  logic             txPktErr,
  input  logic             parityFlag,
  output logic             irqOut
);
  strobe_t          strb;
  logic [REG_W-1:0] evtIn;

  always_comb begin
    evtIn     = '0;
    evtIn[25] = txResetDone;
    evtIn[24] = rxResetDone;
    evtIn[22] = sysErr;
    evtIn[21] = masterAbort;
    evtIn[20] = targetAbort;
    evtIn[16] = rxStatOvr;
    evtIn[14] = phyIrq;
    evtIn[13] = pmEvent;
    evtIn[12] = swiCmd;
    evtIn[11] = statService;
    evtIn[10] = txUnderrun;
    evtIn[8]  = txPktErr;
  end

  irq_agg_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .regSel(regSel),
    .txIdle(txIdle), .parityFlag(parityFlag), .strb(strb)
  );

  irq_agg_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .evtIn(evtIn), .wrData(wrData),
    .rdEn(rdEn), .regSel(regSel), .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: tb/irq_status_agg_test.sv
`timescale 1ns/1ps
module irq_status_agg_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdEn = 0, wrEn = 0, regSel = 0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic txResetDone = 0, rxResetDone = 0, sysErr = 0, masterAbort = 0;
  logic targetAbort = 0, rxStatOvr = 0, phyIrq = 0, pmEvent = 0;
  logic swiCmd = 0, statService = 0, txUnderrun = 0, txPktErr = 0;
  logic txIdle = 1, parityFlag = 0;
  logic irqOut;

  int checks = 0, failures = 0;
  logic [31:0] mStat, mMask;
  logic mPrevTi, mPrevPf, mIrq;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_status_agg uut (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .regSel(regSel),
    .wrData(wrData), .rdData(rdData), .txResetDone(txResetDone),
    .rxResetDone(rxResetDone), .sysErr(sysErr), .masterAbort(masterAbort),
    .targetAbort(targetAbort), .rxStatOvr(rxStatOvr), .phyIrq(phyIrq),
    .pmEvent(pmEvent), .swiCmd(swiCmd), .statService(statService),
    .txUnderrun(txUnderrun), .txIdle(txIdle), .txPktErr(txPktErr),
    .parityFlag(parityFlag), .irqOut(irqOut)
  );

  localparam logic [31:0] STORE = 32'h03F1_7F00;
  localparam logic [31:0] IMPL  = 32'h03F1_FF00;

  function automatic logic [31:0] view(input logic [31:0] s);
    logic [31:0] v;
    v = s & STORE;
    v[15] = |s[25:16];
    return v;
  endfunction

  function automatic int posOf(input int i);
    int p[12] = '{8, 10, 11, 12, 13, 14, 16, 20, 21, 22, 24, 25};
    return p[i];
  endfunction

  function automatic logic [31:0] place(input logic [11:0] ev);
    logic [31:0] v = '0;
    for (int i = 0; i < 12; i++) if (ev[i]) v[posOf(i)] = 1'b1;
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check read data, advance model, check irq
  task automatic step(input logic r, input logic w, input logic s,
                      input logic [31:0] d, input logic [11:0] ev, input string tag);
    logic [31:0] evt;
    rdEn = r; wrEn = w; regSel = s; wrData = d;
    {txResetDone, rxResetDone, sysErr, masterAbort, targetAbort, rxStatOvr,
     phyIrq, pmEvent, swiCmd, statService, txUnderrun, txPktErr} =
      {ev[11], ev[10], ev[9], ev[8], ev[7], ev[6], ev[5], ev[4], ev[3], ev[2], ev[1], ev[0]};
    #0.5;
    if (r) check(tag, rdData, s ? mMask : view(mStat));
    else   check("R3 idle read data", rdData, 32'h0);
    @(posedge clk);
    evt = place(ev);
    if (txIdle && !mPrevTi) evt[9] = 1'b1;
    if (parityFlag && !mPrevPf) evt[23] = 1'b1;
    mStat = (((r && !s) ? 32'h0 : mStat) | evt) & STORE;
    if (w && s) mMask = d & IMPL;
    mIrq = |(view(mStat) & mMask);
    mPrevTi = txIdle; mPrevPf = parityFlag;
    @(negedge clk);
    #0.5;
    check("R9 irqOut", {31'h0, irqOut}, {31'h0, mIrq});
  endtask

  task automatic rdStat(input string tag);
    step(1, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [31:0] snap;
    seed = 1234;
    void'($urandom(seed));
    mStat = 32'h0300_0000; mMask = 0; mPrevTi = 1; mPrevPf = 0; mIrq = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #0.5;
    check("R1 irqOut after reset", {31'h0, irqOut}, 32'h0);
    step(1, 0, 1, 0, 0, "R1 mask reset");
    snap = view(mStat);
    check("R1 status reset model", snap, 32'h0300_8000);
    step(1, 0, 0, 0, 0, "R1 R5 status reset value");
    rdStat("R3 cleared after read");
    // R4: status write ignored
    step(0, 1, 0, 32'hFFFF_FFFF, 0, "R4 write");
    rdStat("R4 status unchanged by write");
    // R8 R10: mask write with reserved bits
    step(0, 1, 1, 32'hFFFF_FFFF, 0, "R8 write mask");
    step(1, 0, 1, 0, 0, "R8 R10 mask readback");
    check("R8 mask expected", mMask, 32'h03F1_FF00);
    step(0, 1, 1, 32'h0, 0, "R8 clear mask");
    // R2: each source alone
    for (int i = 0; i < 12; i++) begin
      step(0, 0, 0, 0, 12'(1 << i), "R2 pulse");
      check("R2 model position", view(mStat),
            (32'h1 << posOf(i)) | ((posOf(i) >= 16) ? 32'h8000 : 32'h0));
      rdStat("R2 R5 single event read");
    end
    // R3: event in the read cycle survives
    step(1, 0, 0, 0, 12'h020, "R3 read with phy pulse");
    rdStat("R3 phy bit kept");
    // R8: mask read does not clear status
    step(0, 0, 0, 0, 12'h001, "R8 set txPktErr");
    step(1, 0, 1, 0, 0, "R8 mask read");
    rdStat("R8 status kept after mask read");
    // R6: transmit idle edges
    txIdle = 0; step(0, 0, 0, 0, 0, "R6 go busy");
    rdStat("R6 fall sets nothing");
    txIdle = 1; step(0, 0, 0, 0, 0, "R6 go idle");
    rdStat("R6 rise sets bit 9");
    step(0, 0, 0, 0, 0, "R6 hold idle");
    rdStat("R6 held idle sets nothing");
    // R7: parity level
    parityFlag = 1; step(0, 0, 0, 0, 0, "R7 raise parity");
    rdStat("R7 parity bit and summary");
    step(0, 0, 0, 0, 0, "R7 hold parity");
    rdStat("R7 held flag not re-set");
    parityFlag = 0; step(0, 0, 0, 0, 0, "R7 drop parity");
    // R9: masking and deassertion
    step(0, 1, 1, 32'h0000_1000, 0, "R9 mask swi only");
    step(0, 0, 0, 0, 12'h004, "R9 unmasked stat event");
    check("R9 no irq for unmasked bit", {31'h0, irqOut}, 32'h0);
    step(0, 0, 0, 0, 12'h008, "R9 swi pulse");
    check("R9 irq raised", {31'h0, irqOut}, 32'h1);
    rdStat("R9 clearing read");
    check("R9 irq dropped after read", {31'h0, irqOut}, 32'h0);
    step(0, 1, 1, 32'h0000_8000, 0, "R9 mask summary");
    step(0, 0, 0, 0, 12'h080, "R9 R5 target abort via summary");
    check("R9 summary irq", {31'h0, irqOut}, 32'h1);
    rdStat("R5 summary read");
    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic r, w, s;
      logic [11:0] ev;
      r = ($urandom % 4) == 0;
      w = ($urandom % 6) == 0;
      s = $urandom % 2;
      ev = 12'($urandom) & 12'($urandom) & 12'($urandom);
      if (($urandom % 8) == 0) txIdle = ~txIdle;
      if (($urandom % 10) == 0) parityFlag = ~parityFlag;
      step(r, w, s, $urandom, ev, s ? "R8 random mask read" : "R3 random status read");
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule